// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns one ARINC 429 bipolar line into 32-bit words. Two comparator outputs that are already digital come in: one says the line is driven high and the other says it is driven low. They pass through a two-stage synchronizer. Then they are sampled on an internal sample enable. In high-speed mode the enable fires once every `TICK_DIV` system clocks, which is meant to be 1 MHz. In low-speed mode it fires `LS_SCALE` times more slowly. At either rate each bit cell spans ten samples: five at the driven level and five at NULL.

Each sample is sorted into one of four classes: ONE, ZERO, NULL, or an illegal both-high state. Three short history registers record the recent ONE, ZERO and NULL samples. A bit is accepted only when its level has held for `QUAL` samples after a qualified NULL. Accepted bits shift into a 32-bit register. A run of `GAP_TICKS` NULL samples closes the word. The word is delivered only if exactly 32 bits arrived since the previous gap. Delivery is a one-cycle strobe together with the word and its odd-parity status.

Malformed sequences never appear at the output. A word with the wrong bit count is dropped and raises a sticky framing flag. A sample with both comparators high raises a sticky line-error flag and discards the word in progress.

Top module: `a429_rx`

## Requirements
- R1: Sampling happens once every `TICK_DIV` clocks when `cfg_low_speed`=0, and once every `TICK_DIV*LS_SCALE` clocks when it is 1. A word timed for the fast rate is not decoded while the slow rate is selected.
- R2: The line classes are: `line_hi`=1 with `line_lo`=0 is ONE, `line_lo`=1 with `line_hi`=0 is ZERO, and both 0 is NULL. A level becomes a bit only after `QUAL` (3) consecutive samples of it that follow a run of `QUAL` NULL samples. A shorter pulse adds no bit and sets no flag.
- R3: The first bit received lands in `word_data[0]` and the 32nd lands in `word_data[31]`.
- R4: A run of `GAP_TICKS` consecutive NULL samples ends a sequence. A word is delivered only at that point, and only if exactly 32 bits were received since the previous gap.
- R5: A sequence of 1 to 31 bits, or of more than 32 bits, that ends in a gap is dropped. It sets `frame_err`, which stays 1 until reset.
- R6: `word_perr` is 1 when the delivered word has an even number of ones, because odd parity over all 32 bits is expected. With `cfg_reject_par`=0 such a word is still delivered.
- R7: With `cfg_reject_par`=1, a word with bad parity is not delivered, and `word_data` and `word_perr` keep their previous values.
- R8: A sample with both inputs at 1 sets `line_err`, which stays 1 until reset. The word in progress is discarded without setting `frame_err`. Bits are ignored until a fresh gap has been seen.
- R9: After reset, bits are ignored until a first gap of `GAP_TICKS` NULL samples has been seen.
- R10: After reset, `word_valid`, `word_data`, `word_perr`, `frame_err` and `line_err` are 0. `word_valid` is high for exactly one clock per word. `word_data` and `word_perr` stay stable until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_hi | input | 1 | Comparator output, line driven high |
| line_lo | input | 1 | Comparator output, line driven low |
| cfg_low_speed | input | 1 | 1 selects the slow line rate |
| cfg_reject_par | input | 1 | 1 drops words with bad parity |
| word_valid | output | 1 | One-clock strobe for a delivered word |
| word_data | output | 32 | Last delivered word, first bit in bit 0 |
| word_perr | output | 1 | Parity status of the last delivered word |
| frame_err | output | 1 | Sticky flag for a wrong bit count |
| line_err | output | 1 | Sticky flag for an illegal both-high sample |

## Verification
Three decisions are taken in the single sample that ends a gap: the end-of-sequence count check, the parity rejection decision, and the setting of the framing flag. The bench drives this with sequences of 31, 32 and 33 bits, with good and bad parity, under both settings of the rejection bit. For each case it judges whether a strobe appeared, what the held word and parity flag contain, and whether the sticky flag is set. It also places a both-high sample inside a word so that error discard and end-of-sequence handling meet in the same sequence. The expected result there is no strobe and no framing flag, and the next clean word still arrives.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    LV_NULL = 2'd0,
    LV_ONE  = 2'd1,
    LV_ZERO = 2'd2,
    LV_BAD  = 2'd3
  } line_lvl_e;

  function automatic line_lvl_e classify(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return LV_ONE;
      2'b01:   return LV_ZERO;
      2'b00:   return LV_NULL;
      default: return LV_BAD;
    endcase
  endfunction

  // Odd parity over the full word is expected; returns 1 on failure.
  function automatic logic parity_fail(input logic [WORD_BITS-1:0] w);
    return ~(^w);
  endfunction

endpackage

// File: rtl/a429_tick_gen.sv
module a429_tick_gen #(
  parameter int TICK_DIV = 50,
  parameter int LS_SCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_speed,
  output logic sample_en
);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam int SW = $clog2(LS_SCALE + 1);

  logic [DW-1:0] div_q;
  logic [SW-1:0] ls_q;
  logic          base_tick;
  logic          slow_tick;

  assign base_tick = (div_q == DW'(TICK_DIV - 1));
  assign slow_tick = base_tick && (ls_q == SW'(LS_SCALE - 1));
  assign sample_en = low_speed ? slow_tick : base_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      ls_q  <= '0;
    end else begin
      div_q <= base_tick ? '0 : div_q + 1'b1;
      if (base_tick) begin
        ls_q <= (ls_q == SW'(LS_SCALE - 1)) ? '0 : ls_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_line_sampler.sv
module a429_line_sampler
  import a429_rx_pkg::*;
#(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  input  logic line_lo,
  input  logic sample_en,
  output logic bit_evt,
  output logic bit_val,
  output logic null_smp,
  output logic err_evt
);
  logic hi_s1, hi_s2, lo_s1, lo_s2;
  logic [QUAL-1:0] ones_q, zeros_q, nulls_q;
  logic [QUAL-1:0] ones_nx, zeros_nx, nulls_nx;
  logic armed_q;
  line_lvl_e lvl;
  logic one_ok, zero_ok, null_ok;

  assign lvl      = classify(hi_s2, lo_s2);
  assign ones_nx  = {ones_q[QUAL-2:0],  lvl == LV_ONE};
  assign zeros_nx = {zeros_q[QUAL-2:0], lvl == LV_ZERO};
  assign nulls_nx = {nulls_q[QUAL-2:0], lvl == LV_NULL};
  assign one_ok   = &ones_nx;
  assign zero_ok  = &zeros_nx;
  assign null_ok  = &nulls_nx;

  assign bit_evt  = sample_en && armed_q && (one_ok || zero_ok);
  assign bit_val  = one_ok;
  assign null_smp = sample_en && (lvl == LV_NULL);
  assign err_evt  = sample_en && (lvl == LV_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_s1   <= 1'b0;
      hi_s2   <= 1'b0;
      lo_s1   <= 1'b0;
      lo_s2   <= 1'b0;
      ones_q  <= '0;
      zeros_q <= '0;
      nulls_q <= '0;
      armed_q <= 1'b0;
    end else begin
      hi_s1 <= line_hi;
      hi_s2 <= hi_s1;
      lo_s1 <= line_lo;
      lo_s2 <= lo_s1;
      if (sample_en) begin
        ones_q  <= ones_nx;
        zeros_q <= zeros_nx;
        nulls_q <= nulls_nx;
        if (err_evt || bit_evt) armed_q <= 1'b0;
        else if (null_ok)       armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_word_framer.sv
module a429_word_framer
  import a429_rx_pkg::*;
#(
  parameter int GAP_TICKS = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 bit_evt,
  input  logic                 bit_val,
  input  logic                 null_smp,
  input  logic                 err_evt,
  input  logic                 reject_par,
  output logic                 gap_evt,
  output logic                 word_valid,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_perr,
  output logic                 frame_err,
  output logic                 line_err
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam int CW = $clog2(WORD_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(WORD_BITS + 1);

  logic [GW-1:0]        null_run_q;
  logic [CW-1:0]        cnt_q;
  logic [WORD_BITS-1:0] shift_q;
  logic                 gap_seen_q;
  logic                 complete, perr_now, deliver;

  assign gap_evt  = null_smp && (null_run_q == GW'(GAP_TICKS - 1));
  assign complete = (cnt_q == CNT_FULL);
  assign perr_now = parity_fail(shift_q);
  assign deliver  = gap_evt && complete && !(perr_now && reject_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      null_run_q <= '0;
      cnt_q      <= '0;
      shift_q    <= '0;
      gap_seen_q <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_perr  <= 1'b0;
      frame_err  <= 1'b0;
      line_err   <= 1'b0;
    end else begin
      word_valid <= deliver;
      if (deliver) begin
        word_data <= shift_q;
        word_perr <= perr_now;
      end
      if (sample_en) begin
        if (!null_smp)                           null_run_q <= '0;
        else if (null_run_q != GW'(GAP_TICKS))   null_run_q <= null_run_q + 1'b1;
      end
      if (err_evt) begin
        cnt_q      <= '0;
        gap_seen_q <= 1'b0;
        line_err   <= 1'b1;
      end else if (gap_evt) begin
        gap_seen_q <= 1'b1;
        cnt_q      <= '0;
        if (cnt_q != '0 && !complete) frame_err <= 1'b1;
      end else if (bit_evt && gap_seen_q) begin
        shift_q <= {bit_val, shift_q[WORD_BITS-1:1]};
        cnt_q   <= (cnt_q == CNT_OVER) ? CNT_OVER : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_rx.sv
module a429_rx
  import a429_rx_pkg::*;
#(
  parameter int TICK_DIV  = 50,
  parameter int LS_SCALE  = 8,
  parameter int QUAL      = 3,
  parameter int GAP_TICKS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_hi,
  input  logic        line_lo,
  input  logic        cfg_low_speed,
  input  logic        cfg_reject_par,
  output logic        word_valid,
  output logic [31:0] word_data,
  output logic        word_perr,
  output logic        frame_err,
  output logic        line_err
);
  logic sample_en;
  logic bit_evt, bit_val, null_smp, err_evt, gap_evt;

  a429_tick_gen #(.TICK_DIV(TICK_DIV), .LS_SCALE(LS_SCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .low_speed(cfg_low_speed), .sample_en(sample_en)
  );

  a429_line_sampler #(.QUAL(QUAL)) u_smp (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .sample_en(sample_en), .bit_evt(bit_evt), .bit_val(bit_val),
    .null_smp(null_smp), .err_evt(err_evt)
  );

  a429_word_framer #(.GAP_TICKS(GAP_TICKS)) u_frm (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .bit_evt(bit_evt),
    .bit_val(bit_val), .null_smp(null_smp), .err_evt(err_evt),
    .reject_par(cfg_reject_par), .gap_evt(gap_evt), .word_valid(word_valid),
    .word_data(word_data), .word_perr(word_perr), .frame_err(frame_err),
    .line_err(line_err)
  );
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_reject_par,
  input logic        sample_en,
  input logic        bit_evt,
  input logic        err_evt,
  input logic        gap_evt,
  input logic        word_valid,
  input logic [31:0] word_data,
  input logic        word_perr,
  input logic        frame_err,
  input logic        line_err
);
  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_evt || err_evt || gap_evt) |-> sample_en); // R1
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_evt, err_evt, gap_evt})); // R2
  AST_DELIVER_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(gap_evt)); // R4
  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R5
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_perr == ~(^word_data))); // R6
  AST_REJECT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(cfg_reject_par)) |-> !word_perr); // R7
  AST_LINE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> line_err); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R10
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(word_data) && $stable(word_perr))); // R10
endmodule

bind a429_rx a429_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reject_par(cfg_reject_par),
  .sample_en(sample_en), .bit_evt(bit_evt), .err_evt(err_evt),
  .gap_evt(gap_evt), .word_valid(word_valid), .word_data(word_data),
  .word_perr(word_perr), .frame_err(frame_err), .line_err(line_err)
);

// File: tb/a429_rx_tb.sv
module a429_rx_tb;
  localparam int TDIV = 4;
  localparam int LSS  = 8;
  localparam int FAST = TDIV;
  localparam int SLOW = TDIV * LSS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_hi = 1'b0, line_lo = 1'b0;
  logic cfg_low_speed = 1'b0, cfg_reject_par = 1'b0;
  logic        word_valid, word_perr, frame_err, line_err;
  logic [31:0] word_data;

  int tests = 0, fails = 0;
  int strobes = 0, width_bad = 0, hold_bad = 0;
  logic prev_valid = 1'b0;
  logic [31:0] last_data = '0;
  logic last_perr = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  a429_rx #(.TICK_DIV(TDIV), .LS_SCALE(LSS), .QUAL(3), .GAP_TICKS(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .cfg_low_speed(cfg_low_speed), .cfg_reject_par(cfg_reject_par),
    .word_valid(word_valid), .word_data(word_data), .word_perr(word_perr),
    .frame_err(frame_err), .line_err(line_err)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_valid = 1'b0;
      last_data  = '0;
      last_perr  = 1'b0;
    end else begin
      if (word_valid) begin
        strobes++;
        if (prev_valid) width_bad++;
        last_data = word_data;
        last_perr = word_perr;
      end else if (word_data !== last_data || word_perr !== last_perr) begin
        hold_bad++;
      end
      prev_valid = word_valid;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] odd_fix(input logic [31:0] w);
    return {~(^w[30:0]), w[30:0]};
  endfunction

  task automatic drive(input logic hi, input logic lo, input int nsamp, input int sp);
    line_hi = hi;
    line_lo = lo;
    repeat (nsamp * sp) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits, input int sp);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 32) ? w[i] : 1'b0;
      drive(b, ~b, 5, sp);
      drive(1'b0, 1'b0, 5, sp);
    end
  endtask

  task automatic gap(input int sp);
    drive(1'b0, 1'b0, 40, sp);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_hi = 1'b0;
    line_lo = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_word(input logic [31:0] w, input logic perr, input string req);
    int s0;
    s0 = strobes;
    send_bits(w, 32, FAST);
    gap(FAST);
    check(strobes == s0 + 1, req, strobes - s0, 1);
    check(word_data === w, req, word_data, w);
    check(word_perr === perr, req, word_perr, perr);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [31:0] w;
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    // R10 reset state
    check(word_valid === 1'b0, "R10 reset valid", word_valid, 0);
    check(word_data === '0, "R10 reset data", word_data, 0);
    check(word_perr === 1'b0 && frame_err === 1'b0 && line_err === 1'b0,
          "R10 reset flags", {word_perr, frame_err, line_err}, 0);
    rst_n = 1'b1;

    // R9: word starts without preceding gap after reset
    s0 = strobes;
    send_bits(odd_fix(32'h1234_5678), 32, FAST);
    gap(FAST);
    check(strobes == s0, "R9 no gap before word", strobes - s0, 0);
    check(frame_err === 1'b0, "R9 no framing flag", frame_err, 0);

    // R3 R4 R6: walking-one sweep with odd parity
    for (int k = 0; k < 32; k++) begin
      w = odd_fix(32'h1 << k);
      expect_word(w, 1'b0, "R3 walking bit");
    end
    for (int k = 0; k < 4; k++) begin
      w = odd_fix(32'h5A5A_5A5A ^ (32'h0F1E_2D3C * (k + 1)));
      expect_word(w, 1'b0, "R4 pattern");
    end

    // R6: bad parity delivered with flag
    w = odd_fix(32'hCAFE_0123) ^ 32'h0000_0100;
    expect_word(w, 1'b1, "R6 bad parity flagged");

    // R7: rejection of bad parity
    cfg_reject_par = 1'b1;
    s0 = strobes;
    send_bits(odd_fix(32'h0BAD_F00D) ^ 32'h1, 32, FAST);
    gap(FAST);
    check(strobes == s0, "R7 rejected word", strobes - s0, 0);
    check(word_data === w, "R7 data held", word_data, w);
    check(word_perr === 1'b1, "R7 perr held", word_perr, 1);
    w = odd_fix(32'h0BAD_F00D);
    expect_word(w, 1'b0, "R7 good word passes");
    cfg_reject_par = 1'b0;

    // R2: short pulses ignored
    s0 = strobes;
    drive(1'b1, 1'b0, 2, FAST);
    drive(1'b0, 1'b0, 40, FAST);
    drive(1'b0, 1'b1, 2, FAST);
    gap(FAST);
    check(strobes == s0, "R2 glitch no word", strobes - s0, 0);
    check(frame_err === 1'b0, "R2 glitch no framing", frame_err, 0);
    expect_word(odd_fix(32'h7777_1111), 1'b0, "R2 word after glitch");

    // R8: illegal both-high sample mid-word
    s0 = strobes;
    w = odd_fix(32'h3C3C_A5A5);
    send_bits(w, 10, FAST);
    drive(1'b1, 1'b1, 1, FAST);
    send_bits(w >> 10, 22, FAST);
    gap(FAST);
    check(strobes == s0, "R8 word discarded", strobes - s0, 0);
    check(line_err === 1'b1, "R8 line flag", line_err, 1);
    check(frame_err === 1'b0, "R8 no framing flag", frame_err, 0);
    expect_word(odd_fix(32'h0000_F00F), 1'b0, "R8 recovery");
    check(line_err === 1'b1, "R8 line flag sticky", line_err, 1);

    // R5: short and long sequences
    do_reset();
    gap(FAST);
    s0 = strobes;
    send_bits(odd_fix(32'h2468_ACE0), 31, FAST);
    gap(FAST);
    check(strobes == s0, "R5 31 bits dropped", strobes - s0, 0);
    check(frame_err === 1'b1, "R5 31 bits flagged", frame_err, 1);
    expect_word(odd_fix(32'h1357_9BDF), 1'b0, "R5 word after short");
    check(frame_err === 1'b1, "R5 flag sticky", frame_err, 1);
    do_reset();
    gap(FAST);
    s0 = strobes;
    send_bits(odd_fix(32'h2468_ACE0), 33, FAST);
    gap(FAST);
    check(strobes == s0, "R5 33 bits dropped", strobes - s0, 0);
    check(frame_err === 1'b1, "R5 33 bits flagged", frame_err, 1);

    // R1: slow rate
    do_reset();
    cfg_low_speed = 1'b1;
    gap(SLOW);
    s0 = strobes;
    w = odd_fix(32'h8421_F0C3);
    send_bits(w, 32, SLOW);
    gap(SLOW);
    check(strobes == s0 + 1, "R1 slow word", strobes - s0, 1);
    check(word_data === w, "R1 slow data", word_data, w);
    s0 = strobes;
    send_bits(odd_fix(32'h1111_2222), 32, FAST);
    gap(SLOW);
    check(strobes == s0, "R1 fast word ignored in slow mode", strobes - s0, 0);
    check(frame_err === 1'b0, "R1 no framing in slow mode", frame_err, 0);
    cfg_low_speed = 1'b0;

    // R10: strobe width and hold over the whole run
    check(width_bad == 0, "R10 strobe width", width_bad, 0);
    check(hold_bad == 0, "R10 data held", hold_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule